// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block generates refresh strobes for a fast-page-mode DRAM that holds 1,024 rows. A free-running interval timer marks when the next distributed refresh falls due. The sequencer then runs a CAS-before-RAS (CBR) cycle in which both column strobes fall first, the row strobe follows, and the part's own row counter picks the row. No row address leaves this block. Host accesses are arbitrated against refresh. A refresh that falls due while the host holds the memory waits for that access to end. It is then served ahead of any new request. A busy flag warns the access controller early that a refresh is waiting.

On request the block enters a low-power self-refresh mode. It does this by holding the row strobe low after a CBR cycle for at least the self-refresh entry time. When the request is withdrawn it raises the row strobe and keeps it high for the exit recovery time. It then either resumes the periodic schedule or runs a back-to-back catch-up burst over every row at the minimum row-cycle spacing. The choice depends on the refresh style input sampled at entry. Host grants stay blocked until the burst has finished. Every timing figure is a parameter counted in clock cycles.

Top module: `fpm_refresh_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `ras_n`, `casl_n`, `cash_n` and `we_n` are 1, and `acc_gnt`, `rfsh_busy` and `sr_active` are 0.
- R2: With no host traffic, successive refresh cycles start (falling `ras_n`) exactly `T_REFI` cycles apart.
- R3: In every refresh cycle `casl_n` and `cash_n` are always equal. They are low for `T_CSR` cycles before `ras_n` falls. `we_n` stays 1 at all times.
- R4: Each ordinary row-strobe low pulse lasts at least `T_RAS` cycles. Each high interval between low pulses lasts at least `T_RP` cycles. Successive falls of `ras_n` are at least `T_RC` cycles apart.
- R5: A refresh that falls due during a host grant raises `rfsh_busy` during the grant. It does not start until `acc_done` ends the grant. It then runs before a still-pending `acc_req` is granted again.
- R6: With no refresh pending, `acc_req` produces `acc_gnt`. `acc_gnt` stays 1 until `acc_done` is seen.
- R7: With `sr_req` at 1, the block runs a CBR cycle and holds `ras_n` and both column strobes low while `sr_active` is 1. The row strobe stays low for at least `T_RASS` cycles in total.
- R8: After `sr_req` returns to 0, `ras_n` stays 1 for at least `T_RPS` cycles before the next row-strobe fall or host grant.
- R9: If `burst_style` was 0 when self-refresh was entered, no refresh burst follows the exit. A waiting `acc_req` is granted with no further `ras_n` fall.
- R10: If `burst_style` was 1 at entry, exactly `ROWS` refresh cycles run after the exit before any host grant. They are spaced at the row-cycle minimum.
- R11: While `acc_gnt` is 1, `ras_n` and the column strobes stay 1, and no refresh cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access controller asks for the memory (level) |
| acc_done | input | 1 | One-cycle pulse ending the granted access |
| sr_req | input | 1 | Level request to stay in self-refresh |
| burst_style | input | 1 | 1: catch-up burst after self-refresh exit; 0: resume periodic refresh |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Low-byte column strobe, active low |
| cash_n | output | 1 | High-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| acc_gnt | output | 1 | Memory granted to the access controller |
| rfsh_busy | output | 1 | Refresh pending, running or bursting |
| sr_active | output | 1 | Memory is held in self-refresh |

## Verification
The scheduler is tested in four situations.

- An idle run: only the timer acts, so the spacing of row-strobe falls shows the interval exactly.
- A long host grant that spans a due point: this separates a refresh that waits and then takes precedence from one that interrupts the grant or is lost.
- A self-refresh with the style input low: this separates a plain resume from an unwanted burst.
- The same self-refresh with the style input high: counting the row-strobe falls before the next grant shows whether the burst covers exactly all rows.

A monitor records every pulse width, fall-to-fall spacing and the strobe order, and compares them against the timing minimums.

// File: rtl/fpm_rfsh_pkg.sv
package fpm_rfsh_pkg;

    // Sequencer phases; the strobe pins are decoded from this value
    typedef enum logic [2:0] {
        ST_IDLE,   // all strobes high, chooses next owner
        ST_ACC,    // host owns the memory
        ST_CSR,    // column strobes low, row strobe still high
        ST_RASL,   // both strobes low (refresh or self-refresh entry)
        ST_SELF,   // held in self-refresh until the request drops
        ST_PRE     // both strobes high, precharge / exit recovery
    } seq_state_e;

endpackage

// File: rtl/fpm_rfsh_interval.sv
module fpm_rfsh_interval #(
    parameter int PERIOD = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == W'(PERIOD - 1));
        cnt_d = (clr || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fpm_rfsh_burst.sv
module fpm_rfsh_burst #(
    parameter int ROWS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic active,
    output logic last
);
    localparam int W = $clog2(ROWS + 1);

    logic [W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load)                     left_d = W'(ROWS);
        else if (step && left_q != 0) left_d = left_q - 1'b1;
        active = (left_q != '0);
        last   = (left_q == W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end
endmodule

// File: rtl/fpm_refresh_seq.sv
module fpm_refresh_seq
    import fpm_rfsh_pkg::*;
#(
    parameter int T_CSR  = 2,
    parameter int T_RAS  = 6,
    parameter int T_RP   = 4,
    parameter int T_RC   = 14,
    parameter int T_RASS = 20,
    parameter int T_RPS  = 12,
    parameter int T_REFI = 400,
    parameter int ROWS   = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    input  logic acc_done,
    input  logic sr_req,
    input  logic burst_style,
    output logic ras_n,
    output logic casl_n,
    output logic cash_n,
    output logic we_n,
    output logic acc_gnt,
    output logic rfsh_busy,
    output logic sr_active
);
    // Precharge stretched so that fall-to-fall spacing meets T_RC
    localparam int RC_GAP  = T_RC - T_RAS - T_CSR;
    localparam int T_PRE   = (T_RP > RC_GAP) ? T_RP : RC_GAP;
    localparam int T_PRE_X = (T_RPS > T_PRE) ? T_RPS : T_PRE;
    localparam int M1      = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int M2      = (T_RASS > T_PRE_X) ? T_RASS : T_PRE_X;
    localparam int MAX_LEN = (M1 > M2) ? M1 : M2;
    localparam int CW      = $clog2(MAX_LEN + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          sr_cyc;     // current CBR cycle enters self-refresh
        logic          from_self;  // precharge is the self-refresh exit
        logic          style;      // burst style captured at entry
        logic          due;        // periodic refresh pending
    } seq_regs_t;

    seq_regs_t q, d;

    logic tick, tmr_clr;
    logic burst_active, burst_last, burst_load, burst_step;
    logic [CW-1:0] ras_len, pre_len;

    assign tmr_clr = (q.st == ST_SELF) || burst_active
                   || (q.st == ST_PRE && q.from_self);

    fpm_rfsh_interval #(.PERIOD(T_REFI)) u_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .tick (tick)
    );

    fpm_rfsh_burst #(.ROWS(ROWS)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (burst_load),
        .step  (burst_step),
        .active(burst_active),
        .last  (burst_last)
    );

    always_comb begin
        d          = q;
        burst_load = 1'b0;
        burst_step = 1'b0;
        ras_len    = q.sr_cyc    ? CW'(T_RASS)  : CW'(T_RAS);
        pre_len    = q.from_self ? CW'(T_PRE_X) : CW'(T_PRE);
        d.due      = q.due | tick;
        d.cnt      = q.cnt + 1'b1;

        case (q.st)
            ST_IDLE: begin
                d.cnt = '0;
                if (q.due) begin
                    d.st     = ST_CSR;
                    d.sr_cyc = 1'b0;
                    d.due    = tick;
                end else if (sr_req) begin
                    d.st     = ST_CSR;
                    d.sr_cyc = 1'b1;
                    d.style  = burst_style;
                end else if (acc_req) begin
                    d.st = ST_ACC;
                end
            end
            ST_ACC: begin
                d.cnt = '0;
                if (acc_done) d.st = ST_IDLE;
            end
            ST_CSR: begin
                if (q.cnt == CW'(T_CSR - 1)) begin
                    d.st  = ST_RASL;
                    d.cnt = '0;
                end
            end
            ST_RASL: begin
                if (q.cnt == ras_len - 1'b1) begin
                    d.st  = q.sr_cyc ? ST_SELF : ST_PRE;
                    d.cnt = '0;
                end
            end
            ST_SELF: begin
                d.cnt = '0;
                if (!sr_req) begin
                    d.st        = ST_PRE;
                    d.sr_cyc    = 1'b0;
                    d.from_self = 1'b1;
                    d.due       = 1'b0;
                end
            end
            ST_PRE: begin
                if (q.cnt == pre_len - 1'b1) begin
                    d.cnt = '0;
                    if (q.from_self) begin
                        d.from_self = 1'b0;
                        d.due       = 1'b0;
                        burst_load  = q.style;
                        d.st        = q.style ? ST_CSR : ST_IDLE;
                    end else if (burst_active) begin
                        burst_step = 1'b1;
                        d.st       = burst_last ? ST_IDLE : ST_CSR;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.cnt       <= '0;
            q.sr_cyc    <= 1'b0;
            q.from_self <= 1'b0;
            q.style     <= 1'b0;
            q.due       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    logic cas_low;
    assign cas_low   = (q.st == ST_CSR) || (q.st == ST_RASL) || (q.st == ST_SELF);
    assign ras_n     = !((q.st == ST_RASL) || (q.st == ST_SELF));
    assign casl_n    = !cas_low;
    assign cash_n    = !cas_low;
    assign we_n      = 1'b1;
    assign acc_gnt   = (q.st == ST_ACC);
    assign sr_active = (q.st == ST_SELF);
    assign rfsh_busy = cas_low || (q.st == ST_PRE) || q.due || burst_active;
endmodule

// File: rtl/fpm_refresh_seq_chk.sv
module fpm_refresh_seq_chk #(
    parameter int T_RAS = 6,
    parameter int T_RP  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic casl_n,
    input logic cash_n,
    input logic we_n,
    input logic acc_gnt,
    input logic sr_active
);
    logic [15:0] low_cnt, high_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= 16'hFFFF;
        end else begin
            low_cnt  <= ras_n ? '0 : ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1);
            high_cnt <= !ras_n ? '0 : ((high_cnt == 16'hFFFF) ? high_cnt : high_cnt + 1'b1);
        end
    end

    a_r3_cas_pair: assert property (@(posedge clk) disable iff (!rst_n)
        casl_n == cash_n);

    a_r3_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        we_n == 1'b1);

    a_r3_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!casl_n));

    a_r4_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_cnt >= 16'(T_RAS)));

    a_r4_ras_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (high_cnt >= 16'(T_RP)));

    a_r11_idle_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (ras_n && casl_n));

    a_r7_self_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!ras_n && !casl_n));
endmodule

bind fpm_refresh_seq fpm_refresh_seq_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .casl_n   (casl_n),
    .cash_n   (cash_n),
    .we_n     (we_n),
    .acc_gnt  (acc_gnt),
    .sr_active(sr_active)
);

// File: tb/fpm_refresh_seq_test.sv
module fpm_refresh_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_CSR  = 2;
    localparam int T_RAS  = 6;
    localparam int T_RP   = 4;
    localparam int T_RC   = 14;
    localparam int T_RASS = 20;
    localparam int T_RPS  = 12;
    localparam int T_REFI = 400;
    localparam int ROWS   = 1024;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_req = 1'b0, acc_done = 1'b0, sr_req = 1'b0, burst_style = 1'b0;
    logic ras_n, casl_n, cash_n, we_n, acc_gnt, rfsh_busy, sr_active;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpm_refresh_seq uut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_done(acc_done),
        .sr_req(sr_req), .burst_style(burst_style), .ras_n(ras_n),
        .casl_n(casl_n), .cash_n(cash_n), .we_n(we_n), .acc_gnt(acc_gnt),
        .rfsh_busy(rfsh_busy), .sr_active(sr_active)
    );

    int checks = 0, errors = 0;

    // Strobe monitor, sampled on the falling edge
    int cyc, falls, last_fall, last_spacing, min_spacing;
    int low_run, high_run, last_low_w, last_high_w, min_low_w, min_high_w;
    int cas_run, bad_order, bad_pair, bad_we, bad_overlap;
    logic prev_ras;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; falls = 0; last_fall = 0; last_spacing = 0;
            min_spacing = 1000000; low_run = 0; high_run = 0;
            last_low_w = 0; last_high_w = 0; min_low_w = 1000000;
            min_high_w = 1000000; cas_run = 0; bad_order = 0;
            bad_pair = 0; bad_we = 0; bad_overlap = 0; prev_ras = 1'b1;
        end else begin
            cyc++;
            cas_run = casl_n ? 0 : cas_run + 1;
            if (casl_n !== cash_n) bad_pair++;
            if (we_n !== 1'b1) bad_we++;
            if (acc_gnt && (!ras_n || !casl_n)) bad_overlap++;
            if (!ras_n) begin
                if (prev_ras) begin
                    falls++;
                    last_high_w = high_run;
                    if (high_run < min_high_w) min_high_w = high_run;
                    if (falls > 1) begin
                        last_spacing = cyc - last_fall;
                        if (last_spacing < min_spacing) min_spacing = last_spacing;
                    end
                    last_fall = cyc;
                    if (cas_run <= T_CSR) bad_order++;
                    low_run = 1;
                end else low_run++;
            end else begin
                if (!prev_ras) begin
                    last_low_w = low_run;
                    if (low_run < min_low_w) min_low_w = low_run;
                    high_run = 1;
                end else high_run++;
            end
            prev_ras = ras_n;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_gnt(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            if (acc_gnt) begin
                seen = 1'b1;
                break;
            end
            tick();
        end
    endtask

    task automatic pulse_done();
        acc_done = 1'b1;
        tick();
        acc_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) tick();
        check(ras_n && casl_n && cash_n && we_n, "R1", "strobes high in reset",
              {ras_n, casl_n, cash_n, we_n}, 15);
        check(!acc_gnt && !rfsh_busy && !sr_active, "R1", "flags low in reset",
              {acc_gnt, rfsh_busy, sr_active}, 0);
        rst_n = 1'b1;
        tick();
        check(ras_n && casl_n && !acc_gnt && !rfsh_busy && !sr_active, "R1",
              "idle after reset", {ras_n, casl_n, acc_gnt, rfsh_busy, sr_active}, 24);
    endtask

    task automatic t_periodic();
        for (int i = 0; i < 3 * T_REFI + 100 && falls < 3; i++) tick();
        check(falls == 3, "R2", "refresh count after three intervals", falls, 3);
        check(last_spacing == T_REFI, "R2", "refresh spacing", last_spacing, T_REFI);
        check(bad_order == 0, "R3", "CAS not ahead of RAS by T_CSR", bad_order, 0);
    endtask

    task automatic t_arbitration();
        int  f1;
        bit  seen, busy_seen, gnt_dropped;
        int  start_falls = falls;
        for (int i = 0; i < T_REFI + 20 && falls == start_falls; i++) tick();
        acc_req = 1'b1;
        wait_gnt(50, seen);
        check(seen, "R6", "grant after refresh ends", seen, 1);
        f1 = falls;
        busy_seen = 1'b0;
        gnt_dropped = 1'b0;
        for (int i = 0; i < T_REFI + 30; i++) begin
            tick();
            if (acc_gnt && rfsh_busy) busy_seen = 1'b1;
            if (!acc_gnt) gnt_dropped = 1'b1;
        end
        check(!gnt_dropped, "R6", "grant held until done", gnt_dropped, 0);
        check(busy_seen, "R5", "busy raised while refresh waits", busy_seen, 1);
        check(falls == f1, "R11", "no refresh during grant", falls - f1, 0);
        pulse_done();
        wait_gnt(60, seen);
        check(seen, "R5", "request granted again", seen, 1);
        check(falls == f1 + 1, "R5", "waiting refresh ran before regrant",
              falls - f1, 1);
        acc_req = 1'b0;
        pulse_done();
        tick();
    endtask

    task automatic t_self_dist();
        int  f0;
        bit  seen, held;
        burst_style = 1'b0;
        sr_req = 1'b1;
        for (int i = 0; i < 200 && !sr_active; i++) tick();
        check(sr_active, "R7", "self-refresh entered", sr_active, 1);
        held = 1'b1;
        for (int i = 0; i < 50; i++) begin
            tick();
            if (ras_n || casl_n || !sr_active) held = 1'b0;
        end
        check(held, "R7", "strobes held low in self-refresh", held, 1);
        sr_req = 1'b0;
        acc_req = 1'b1;
        f0 = falls;
        wait_gnt(100, seen);
        check(seen, "R9", "grant after distributed exit", seen, 1);
        check(falls == f0, "R9", "no burst after distributed exit", falls - f0, 0);
        check(high_run >= T_RPS, "R8", "exit recovery before grant", high_run, T_RPS);
        check(last_low_w >= T_RASS, "R7", "self-refresh RAS low width",
              last_low_w, T_RASS);
        acc_req = 1'b0;
        pulse_done();
        tick();
    endtask

    task automatic t_self_burst();
        int  f0;
        bit  seen;
        burst_style = 1'b1;
        sr_req = 1'b1;
        for (int i = 0; i < 200 && !sr_active; i++) tick();
        check(sr_active, "R7", "self-refresh entered (burst style)", sr_active, 1);
        repeat (10) tick();
        sr_req = 1'b0;
        burst_style = 1'b0;
        acc_req = 1'b1;
        f0 = falls;
        min_spacing = 1000000;
        for (int i = 0; i < 100 && falls == f0; i++) tick();
        check(last_high_w >= T_RPS, "R8", "RAS high before first burst refresh",
              last_high_w, T_RPS);
        wait_gnt(ROWS * T_RC * 2, seen);
        check(seen, "R10", "grant after burst", seen, 1);
        check(falls - f0 == ROWS, "R10", "burst refresh count", falls - f0, ROWS);
        check(min_spacing >= T_RC, "R10", "burst spacing", min_spacing, T_RC);
        acc_req = 1'b0;
        pulse_done();
        tick();
    endtask

    task automatic t_global();
        check(bad_pair == 0, "R3", "column strobes differ", bad_pair, 0);
        check(bad_we == 0, "R3", "write enable left high", bad_we, 0);
        check(bad_order == 0, "R3", "CBR order", bad_order, 0);
        check(bad_overlap == 0, "R11", "strobes active during grant", bad_overlap, 0);
        check(min_low_w >= T_RAS, "R4", "minimum RAS low width", min_low_w, T_RAS);
        check(min_high_w >= T_RP, "R4", "minimum RAS high width", min_high_w, T_RP);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R0: watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_periodic();
        t_arbitration();
        t_self_dist();
        t_self_burst();
        t_global();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule